// File: doc/BRIEF.md
# Adaptive Per-Thread Phase Predictor

This block keeps, for each of several hardware threads, a running guess of whether that thread is in a compute phase or in a memory phase. It watches two pulse streams per thread: instruction-commit pulses and last-level cache-miss pulses. From these streams it reports a phase bit and the most recent commit interval for every thread. A memory request scheduler can use both values to rank the threads' requests.

Each thread has an interval counter and a distance counter. The interval counter counts commits between two misses. At each miss the interval is compared against a threshold that all threads share. A short interval counts as a close miss and grows the distance counter. A long interval clears the distance counter and puts the thread in compute phase. The thread enters memory phase when its distance count rises above a per-thread distance threshold.

That distance threshold is not fixed. While a thread is in compute phase, the block measures each burst of close misses that ends with a long interval. It then sets the threshold to the longest such burst seen so far, kept within a programmable ceiling and never below one. As a result, a thread whose compute bursts are short is moved to memory phase sooner.

Top module: `thread_phase_predictor`

## Requirements
- R1: After reset, every thread is in compute phase (phase bit 0), every reported interval is 0, and every thread's distance threshold equals the default input sampled during reset.
- R2: A thread's interval counts its commit pulses since that thread's previous miss. On a miss, the count is reported on that thread's interval field in the cycle after the miss, and counting restarts from zero.
- R3: A miss whose interval is strictly greater than the shared interval threshold is long. It clears the thread's distance counter and sets the thread's phase to compute. An interval equal to the threshold counts as close.
- R4: A close miss adds one to the distance counter. When the counter becomes greater than the thread's distance threshold, the phase bit changes to 1 (memory) in the cycle after that miss.
- R5: A thread in memory phase stays there through further close misses and returns to compute phase at its first long miss.
- R6: A long miss that ends a non-empty run of close misses while the thread is in compute phase records that run length. The distance threshold then becomes the longest run recorded since reset, limited to the ceiling input and never below 1. Runs that end in memory phase are not recorded.
- R7: The interval counter and the distance counter saturate at their all-ones values and never wrap.
- R8: When a commit pulse and a miss pulse for the same thread arrive in the same cycle, the commit is included in the interval that is compared and reported.
- R9: Threads are independent. One thread's pulses never change another thread's phase, interval or threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| commit_i | input | NTHREADS | Commit pulse, one bit per thread |
| miss_i | input | NTHREADS | Cache-miss pulse, one bit per thread |
| intv_thresh_i | input | ICNT_W | Interval threshold shared by all threads |
| dist_ceil_i | input | DCNT_W | Upper limit for the learned distance threshold |
| dist_dflt_i | input | DCNT_W | Distance threshold loaded during reset |
| mem_phase_o | output | NTHREADS | Phase bit per thread: 1 for memory, 0 for compute |
| intv_last_o | output | NTHREADS*ICNT_W | Interval at each thread's latest miss; thread t occupies bits [t*ICNT_W +: ICNT_W] |

## Verification
The tests drive misses whose intervals lie below, exactly on, and just above the shared threshold. This shows that equality counts as close. It also checks how a same-cycle commit shifts the comparison. Bursts of close misses are run against the reset default, against a threshold learned from one short burst, and against a later shorter burst. These runs show that the learned value comes from the longest run and that the first close miss past it switches the phase. A long burst under a large default shows the ceiling limit. Long commit streams and long miss trains show that both counters saturate without wrapping, and pulses on one thread are checked against the other threads' outputs.

// File: rtl/thread_phase_pkg.sv
package thread_phase_pkg;
  typedef enum logic {
    PH_COMPUTE = 1'b0,
    PH_MEMORY  = 1'b1
  } phase_e;
endpackage

// File: rtl/tpp_interval_ctr.sv
module tpp_interval_ctr #(
  parameter int ICNT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_i,
  input  logic              miss_i,
  input  logic [ICNT_W-1:0] thresh_i,
  output logic              long_o,
  output logic [ICNT_W-1:0] last_o
);
  localparam logic [ICNT_W-1:0] IMAX = '1;

  logic [ICNT_W-1:0] cnt_q;
  logic [ICNT_W-1:0] ival;

  // commit of this cycle is folded in before the comparison (R8)
  always_comb begin
    ival = cnt_q;
    if (commit_i && cnt_q != IMAX) ival = cnt_q + 1'b1;
  end

  assign long_o = ival > thresh_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      last_o <= '0;
    end else if (miss_i) begin
      cnt_q  <= '0;
      last_o <= ival;
    end else begin
      cnt_q  <= ival;
    end
  end

  // R2: counting restarts after every miss
  p_restart_r2: assert property (@(posedge clk) disable iff (rst)
    miss_i |=> cnt_q == '0);

  // R7: a full counter stays full without a miss
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (!miss_i && cnt_q == IMAX) |=> cnt_q == IMAX);

  // R2: reported interval changes only after a miss
  p_last_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !miss_i |=> $stable(last_o));
endmodule

// File: rtl/tpp_phase_track.sv
module tpp_phase_track
  import thread_phase_pkg::*;
#(
  parameter int DCNT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_i,
  input  logic              long_i,
  input  logic [DCNT_W-1:0] ceil_i,
  input  logic [DCNT_W-1:0] dflt_i,
  output logic              mem_o
);
  localparam logic [DCNT_W-1:0] DMAX = '1;
  localparam logic [DCNT_W-1:0] ONE  = DCNT_W'(1);

  phase_e            ph_q;
  logic [DCNT_W-1:0] dcnt_q;
  logic [DCNT_W-1:0] thr_q;
  logic [DCNT_W-1:0] runmax_q;
  logic [DCNT_W-1:0] dinc;
  logic [DCNT_W-1:0] run_new;
  logic [DCNT_W-1:0] ceil_eff;
  logic [DCNT_W-1:0] thr_new;
  logic              record;

  assign dinc     = (dcnt_q == DMAX) ? DMAX : dcnt_q + 1'b1;
  assign record   = miss_i && long_i && ph_q == PH_COMPUTE && dcnt_q != '0;
  assign run_new  = (dcnt_q > runmax_q) ? dcnt_q : runmax_q;
  assign ceil_eff = (ceil_i == '0) ? ONE : ceil_i;
  assign thr_new  = (run_new > ceil_eff) ? ceil_eff : run_new;
  assign mem_o    = (ph_q == PH_MEMORY);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= PH_COMPUTE;
      dcnt_q   <= '0;
      runmax_q <= '0;
      thr_q    <= dflt_i;
    end else if (miss_i) begin
      if (long_i) begin
        ph_q   <= PH_COMPUTE;
        dcnt_q <= '0;
        if (record) begin
          runmax_q <= run_new;
          thr_q    <= thr_new;
        end
      end else begin
        dcnt_q <= dinc;
        if (dinc > thr_q) ph_q <= PH_MEMORY;
      end
    end
  end

  // R4/R5: the phase moves only in the cycle after a miss
  p_phase_on_miss_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(ph_q) |-> $past(miss_i));

  // R3: a long miss leaves the thread in compute with zero distance
  p_long_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (miss_i && long_i) |=> (dcnt_q == '0 && ph_q == PH_COMPUTE));

  // R5: close misses never bring a memory thread back
  p_mem_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (miss_i && !long_i && ph_q == PH_MEMORY) |=> ph_q == PH_MEMORY);

  // R6: a learned threshold lies within [1, ceiling]
  p_thr_range_r6: assert property (@(posedge clk) disable iff (rst)
    record |=> (thr_q != '0 && thr_q <= $past(ceil_eff)));

  // R7: distance counter saturates
  p_dist_sat_r7: assert property (@(posedge clk) disable iff (rst)
    (miss_i && !long_i && dcnt_q == DMAX) |=> dcnt_q == DMAX);
endmodule

// File: rtl/thread_phase_predictor.sv
module thread_phase_predictor #(
  parameter int NTHREADS = 4,
  parameter int ICNT_W   = 12,
  parameter int DCNT_W   = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NTHREADS-1:0]        commit_i,
  input  logic [NTHREADS-1:0]        miss_i,
  input  logic [ICNT_W-1:0]          intv_thresh_i,
  input  logic [DCNT_W-1:0]          dist_ceil_i,
  input  logic [DCNT_W-1:0]          dist_dflt_i,
  output logic [NTHREADS-1:0]        mem_phase_o,
  output logic [NTHREADS*ICNT_W-1:0] intv_last_o
);
  localparam int IW_ALL = NTHREADS * ICNT_W;

  logic [NTHREADS-1:0] long_w;
  logic [IW_ALL-1:0]   last_w;

  for (genvar t = 0; t < NTHREADS; t++) begin : g_thr
    tpp_interval_ctr #(.ICNT_W(ICNT_W)) u_ictr (
      .clk      (clk),
      .rst      (rst),
      .commit_i (commit_i[t]),
      .miss_i   (miss_i[t]),
      .thresh_i (intv_thresh_i),
      .long_o   (long_w[t]),
      .last_o   (last_w[t*ICNT_W +: ICNT_W])
    );

    tpp_phase_track #(.DCNT_W(DCNT_W)) u_ph (
      .clk    (clk),
      .rst    (rst),
      .miss_i (miss_i[t]),
      .long_i (long_w[t]),
      .ceil_i (dist_ceil_i),
      .dflt_i (dist_dflt_i),
      .mem_o  (mem_phase_o[t])
    );
  end

  assign intv_last_o = last_w;

  // R9: a thread without a miss keeps its phase
  for (genvar t = 0; t < NTHREADS; t++) begin : g_chk
    p_indep_r9: assert property (@(posedge clk) disable iff (rst)
      !miss_i[t] |=> $stable(mem_phase_o[t]));
  end
endmodule

// File: tb/test_thread_phase_predictor.sv
module test_thread_phase_predictor;
  localparam int N  = 4;
  localparam int IW = 6;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  commit_v = '0;
  logic [N-1:0]  miss_v   = '0;
  logic [IW-1:0] ithr     = IW'(8);
  logic [DW-1:0] dceil    = DW'(6);
  logic [DW-1:0] ddflt    = DW'(4);
  logic [N-1:0]  mem_ph;
  logic [N*IW-1:0] intv;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  thread_phase_predictor #(.NTHREADS(N), .ICNT_W(IW), .DCNT_W(DW)) i_thread_phase_predictor (
    .clk(clk), .rst(rst), .commit_i(commit_v), .miss_i(miss_v),
    .intv_thresh_i(ithr), .dist_ceil_i(dceil), .dist_dflt_i(ddflt),
    .mem_phase_o(mem_ph), .intv_last_o(intv)
  );

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int iv(int t);
    return int'(intv[t*IW +: IW]);
  endfunction

  task automatic do_reset(int dflt);
    rst = 1'b1;
    ddflt = DW'(dflt);
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic commits(int t, int n);
    for (int i = 0; i < n; i++) begin
      commit_v[t] = 1'b1;
      @(negedge clk);
    end
    commit_v[t] = 1'b0;
  endtask

  task automatic miss(int t, bit with_commit);
    miss_v[t] = 1'b1;
    commit_v[t] = with_commit;
    @(negedge clk);
    miss_v[t] = 1'b0;
    commit_v[t] = 1'b0;
  endtask

  task automatic close_misses(int t, int k);
    for (int i = 0; i < k; i++) miss(t, 1'b0);
  endtask

  task automatic t_reset;
    chk(int'(mem_ph), 0, "R1 phase after reset");
    for (int t = 0; t < N; t++) chk(iv(t), 0, "R1 interval after reset");
  endtask

  task automatic t_interval;
    commits(0, 10);
    miss(0, 1'b0);
    chk(iv(0), 10, "R2 interval of 10 commits");
    chk(int'(mem_ph[0]), 0, "R3 long miss gives compute");
    chk(iv(1), 0, "R9 other thread interval untouched");
    commits(0, 3);
    miss(0, 1'b0);
    chk(iv(0), 3, "R2 counter restarted after miss");
  endtask

  task automatic t_same_cycle;
    commits(0, 4);
    miss(0, 1'b1);
    chk(iv(0), 5, "R8 same-cycle commit counted");
    commits(0, 8);
    miss(0, 1'b1);
    chk(iv(0), 9, "R8 commit pushes interval to 9");
    chk(int'(mem_ph[0]), 0, "R3 interval 9 is long");
  endtask

  task automatic t_default_thr;
    for (int i = 0; i < 4; i++) begin
      commits(1, 8);
      miss(1, 1'b0);
    end
    chk(iv(1), 8, "R3 equal interval reported");
    chk(int'(mem_ph[1]), 0, "R4 four close misses stay under default 4");
    chk(int'(mem_ph[0]), 0, "R9 thread 0 unaffected");
    commits(1, 8);
    miss(1, 1'b0);
    chk(int'(mem_ph[1]), 1, "R4 fifth close miss exceeds default");
    close_misses(1, 2);
    chk(int'(mem_ph[1]), 1, "R5 memory phase holds on close misses");
    commits(1, 9);
    miss(1, 1'b0);
    chk(int'(mem_ph[1]), 0, "R5 long miss returns to compute");
    close_misses(1, 4);
    chk(int'(mem_ph[1]), 0, "R6 memory-phase run not recorded");
    close_misses(1, 1);
    chk(int'(mem_ph[1]), 1, "R6 threshold still default 4");
  endtask

  task automatic t_learn;
    commits(2, 9); miss(2, 1'b0);
    close_misses(2, 2);
    commits(2, 9); miss(2, 1'b0);
    close_misses(2, 2);
    chk(int'(mem_ph[2]), 0, "R6 two close misses within learned 2");
    close_misses(2, 1);
    chk(int'(mem_ph[2]), 1, "R6 third close miss past learned 2");
  endtask

  task automatic t_max;
    commits(3, 9); miss(3, 1'b0);
    close_misses(3, 3);
    commits(3, 9); miss(3, 1'b0);
    close_misses(3, 1);
    commits(3, 9); miss(3, 1'b0);
    close_misses(3, 3);
    chk(int'(mem_ph[3]), 0, "R6 threshold keeps longest run 3");
    close_misses(3, 1);
    chk(int'(mem_ph[3]), 1, "R6 fourth close miss past 3");
  endtask

  task automatic t_saturate;
    commits(0, 70);
    miss(0, 1'b0);
    chk(iv(0), 63, "R7 interval saturates at 63");
    close_misses(0, 20);
    chk(int'(mem_ph[0]), 1, "R7 memory after long close run");
    commits(0, 9);
    miss(0, 1'b0);
    chk(int'(mem_ph[0]), 0, "R7 long miss after saturated distance");
  endtask

  task automatic t_ceiling;
    do_reset(10);
    t_reset;
    commits(0, 9); miss(0, 1'b0);
    close_misses(0, 8);
    chk(int'(mem_ph[0]), 0, "R1 default 10 tolerates 8 close");
    commits(0, 9); miss(0, 1'b0);
    close_misses(0, 6);
    chk(int'(mem_ph[0]), 0, "R6 ceiling 6 allows 6 close");
    close_misses(0, 1);
    chk(int'(mem_ph[0]), 1, "R6 seventh close past ceiling");
  endtask

  initial begin
    do_reset(4);
    t_reset;
    t_interval;
    t_same_cycle;
    t_default_thr;
    t_learn;
    t_max;
    t_saturate;
    t_ceiling;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule